// File: doc/BRIEF.md
# USB Frame Timer with Done-Queue Delay

This block paces the 1 ms frames of a USB host controller from a 12 MHz bit-time tick. It holds the programmable frame interval word, a down-counter of the bit times left in the current frame, the frame number and the toggle bit that software flips when it reprograms the interval. Frames run only while the controller's functional state input reads operational. Each frame start raises a one-cycle start-of-frame pulse. A second pulse marks every change of the frame number's top bit.

The same frame boundary drives a small delay counter. This counter decides when the list of retired transfers is handed back to software. Each retired transfer carries a 3-bit delay request, and the counter keeps the smallest one. The counter then steps down once per frame. When it reaches zero at a boundary, and no earlier writeback interrupt is still pending, the block issues a writeback request. With that request it reports whether any enabled interrupt is pending, which goes into bit 0 of the written head. The block has no memory port. The writeback itself and the interrupt status register live in neighbouring logic.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the interval address (0) reads 0x2778_2EDF (interval 0x2EDF in bits 13:0, largest-packet 0x2778 in bits 30:16, toggle 0 in bit 31). The remaining-time address (1) reads 0, the frame-number address (2) reads 0 and the threshold address (3) reads 0x628.
- R2: A write to address 0 stores bits 13:0, 30:16 and 31. Bits 15:14 always read back as zero.
- R3: A write to address 3 keeps only bits 11:0. Writes to addresses 1 and 2 change nothing that can be read.
- R4: When the state input changes to operational (2'b10) from any other value, a start-of-frame pulse appears one cycle later. The remaining count is then loaded with the interval, and the frame number does not change.
- R5: While operational, every bit tick lowers the remaining count by one. A tick that finds the count at zero is a frame boundary. At a boundary the count reloads from the interval, the frame number increments modulo 2^FNUM_W, and a start-of-frame pulse follows. With the tick held high, a frame lasts interval+1 cycles.
- R6: While operational, the remaining-time address returns the remaining toggle in bit 31 and the count in bits 13:0. In any other state it returns only the toggle bit.
- R7: The remaining toggle takes the interval toggle's value at each frame boundary, and at no other time.
- R8: Outside the operational state, including suspend (2'b11), no start-of-frame pulse occurs and the frame number holds its value.
- R9: The overflow pulse accompanies exactly those start-of-frame pulses whose boundary changed the top bit of the frame number.
- R10: The delay counter resets to 7. A retired transfer lowers it to the transfer's delay only when that delay is smaller than the counter's value.
- R11: At a boundary where the counter is 0 and the writeback-pending input is low, a writeback request pulses together with the start-of-frame pulse. Its flag output equals the any-enabled-interrupt input, and the counter returns to 7.
- R12: While the writeback-pending input is high, a counter at 0 stays at 0 and no writeback request is issued.
- R13: At a boundary without a writeback, the counter drops by one only when its value is neither 7 nor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per USB bit time |
| hc_state | input | 2 | Controller functional state; 2'b10 is operational |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 interval, 3 threshold |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 interval, 1 remaining, 2 frame number, 3 threshold |
| rd_data | output | 32 | Combinational read value |
| retire_vld | input | 1 | A transfer was retired this cycle |
| retire_dly | input | DLY_W | Delay requested by the retired transfer, in frames |
| wb_pend_i | input | 1 | A writeback interrupt is still pending |
| irq_any_i | input | 1 | Some enabled interrupt is pending |
| sof_o | output | 1 | Start-of-frame pulse |
| fno_o | output | 1 | Frame-number top-bit change pulse |
| wb_req_o | output | 1 | Writeback request pulse |
| wb_flag_o | output | 1 | Value for bit 0 of the written head, valid with wb_req_o |

## Verification
The bench builds the block with FNUM_W set to 6 and DLY_W left at 3. It programs an interval of 3, which gives four-cycle frames. A run of about a hundred frames therefore passes the frame-number top bit in both directions and wraps the counter, so the overflow pulse and the modulo step are both checked. The 3-bit delay keeps every counter value from 7 to 0 within a few frames. This makes the minimum merge, the hold at zero while a writeback is pending, and the no-decrement rule at 7 all reachable in short runs.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;
  localparam int IVL_W   = 14;
  localparam int LST_W   = 12;
  localparam int WORD_W  = 32;

  localparam logic [WORD_W-1:0] IVL_WORD_RST  = 32'h2778_2EDF;
  localparam logic [WORD_W-1:0] IVL_WORD_MASK = 32'hFFFF_3FFF;
  localparam logic [LST_W-1:0]  LST_RST       = 12'h628;

  typedef enum logic [1:0] {
    ST_RESET  = 2'b00,
    ST_RESUME = 2'b01,
    ST_OPER   = 2'b10,
    ST_SUSP   = 2'b11
  } hc_state_e;

  typedef enum logic [1:0] {
    RA_IVL  = 2'b00,
    RA_REM  = 2'b01,
    RA_FNUM = 2'b10,
    RA_LST  = 2'b11
  } reg_addr_e;
endpackage

// File: rtl/uft_interval_regs.sv
module uft_interval_regs
  import usb_frame_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ivl_word,
  output logic [LST_W-1:0]  lst
);
  logic [WORD_W-1:0] ivl_word_d, ivl_word_q;
  logic [LST_W-1:0]  lst_d, lst_q;
  logic              ivl_we, lst_we;

  assign ivl_we = wr_en && (wr_addr == RA_IVL);
  assign lst_we = wr_en && (wr_addr == RA_LST);

  always_comb begin
    ivl_word_d = ivl_word_q;
    lst_d      = lst_q;
    if (ivl_we) ivl_word_d = wr_data & IVL_WORD_MASK;
    if (lst_we) lst_d      = wr_data[LST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_word_q <= IVL_WORD_RST;
      lst_q      <= LST_RST;
    end else begin
      ivl_word_q <= ivl_word_d;
      lst_q      <= lst_d;
    end
  end

  assign ivl_word = ivl_word_q;
  assign lst      = lst_q;

  // R2: reserved interval bits never become set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_word_q[15:14] == 2'b00);
endmodule

// File: rtl/uft_frame_core.sv
module uft_frame_core
  import usb_frame_timer_pkg::*;
#(
  parameter int FNUM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [1:0]        hc_state,
  input  logic [IVL_W-1:0]  ivl,
  input  logic              ivl_tgl,
  output logic              frame_edge,
  output logic              sof_o,
  output logic              fno_o,
  output logic [FNUM_W-1:0] fnum,
  output logic [IVL_W-1:0]  rem,
  output logic              rem_tgl
);
  localparam int MSB = FNUM_W - 1;

  logic              oper_now, oper_q, enter;
  logic [IVL_W-1:0]  rem_d, rem_q;
  logic [FNUM_W-1:0] fnum_d, fnum_q;
  logic              rtg_d, rtg_q;
  logic              sof_d, sof_q, fno_d, fno_q;

  assign oper_now   = (hc_state == ST_OPER);
  assign enter      = oper_now && !oper_q;
  assign frame_edge = oper_now && oper_q && bit_tick && (rem_q == '0);

  always_comb begin
    rem_d  = rem_q;
    fnum_d = fnum_q;
    rtg_d  = rtg_q;
    sof_d  = 1'b0;
    fno_d  = 1'b0;
    if (enter) begin
      rem_d = ivl;
      sof_d = 1'b1;
    end else if (frame_edge) begin
      rem_d  = ivl;
      fnum_d = fnum_q + 1'b1;
      rtg_d  = ivl_tgl;
      sof_d  = 1'b1;
      fno_d  = fnum_d[MSB] ^ fnum_q[MSB];
    end else if (oper_now && oper_q && bit_tick) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oper_q <= 1'b0;
      rem_q  <= '0;
      fnum_q <= '0;
      rtg_q  <= 1'b0;
      sof_q  <= 1'b0;
      fno_q  <= 1'b0;
    end else begin
      oper_q <= oper_now;
      rem_q  <= rem_d;
      fnum_q <= fnum_d;
      rtg_q  <= rtg_d;
      sof_q  <= sof_d;
      fno_q  <= fno_d;
    end
  end

  assign sof_o   = sof_q;
  assign fno_o   = fno_q;
  assign fnum    = fnum_q;
  assign rem     = rem_q;
  assign rem_tgl = rtg_q;

  // R5: the frame number only ever moves forward by one
  a_r5_fnum_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fnum_q != $past(fnum_q)) |-> (fnum_q == FNUM_W'($past(fnum_q) + 1'b1)));
  // R8: start-of-frame needs the operational state one cycle earlier
  a_r8_sof_needs_oper: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> ($past(hc_state) == ST_OPER));
  // R8: frame number frozen outside operational
  a_r8_fnum_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hc_state) != ST_OPER) |-> $stable(fnum_q));
  // R9: overflow pulse only alongside start-of-frame
  a_r9_fno_with_sof: assert property (@(posedge clk) disable iff (!rst_n)
    fno_q |-> sof_q);
  // R7: the remaining toggle changes only together with a start-of-frame
  a_r7_tgl_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rtg_q != $past(rtg_q)) |-> sof_q);
endmodule

// File: rtl/uft_done_delay.sv
module uft_done_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_edge,
  input  logic             retire_vld,
  input  logic [DLY_W-1:0] retire_dly,
  input  logic             wb_pend_i,
  input  logic             irq_any_i,
  output logic             wb_req_o,
  output logic             wb_flag_o
);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  logic [DLY_W-1:0] dc_d, dc_q, eff;
  logic             wb_d, wb_q, flag_d, flag_q;

  assign eff = (retire_vld && (retire_dly < dc_q)) ? retire_dly : dc_q;

  always_comb begin
    dc_d   = eff;
    wb_d   = 1'b0;
    flag_d = 1'b0;
    if (frame_edge) begin
      if ((eff == '0) && !wb_pend_i) begin
        wb_d   = 1'b1;
        flag_d = irq_any_i;
        dc_d   = DLY_MAX;
      end else if ((eff != DLY_MAX) && (eff != '0)) begin
        dc_d = eff - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q   <= DLY_MAX;
      wb_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      dc_q   <= dc_d;
      wb_q   <= wb_d;
      flag_q <= flag_d;
    end
  end

  assign wb_req_o  = wb_q;
  assign wb_flag_o = flag_q;

  // R11: a writeback follows a boundary seen with no pending writeback
  a_r11_wb_cond: assert property (@(posedge clk) disable iff (!rst_n)
    wb_q |-> ($past(frame_edge) && !$past(wb_pend_i)));
  // R13: the counter only rises when a writeback re-arms it
  a_r13_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_q > $past(dc_q)) |-> wb_q);
  // R12: a zero counter holds while a writeback is pending
  a_r12_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dc_q) == '0 && $past(wb_pend_i)) |-> (dc_q == '0));
  // R11: flag is only meaningful with a request
  a_r11_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> wb_q);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_frame_timer_pkg::*;
#(
  parameter int FNUM_W = 16,
  parameter int DLY_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [1:0]       hc_state,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             retire_vld,
  input  logic [DLY_W-1:0] retire_dly,
  input  logic             wb_pend_i,
  input  logic             irq_any_i,
  output logic             sof_o,
  output logic             fno_o,
  output logic             wb_req_o,
  output logic             wb_flag_o
);
  localparam int REM_PAD  = WORD_W - 1 - IVL_W;
  localparam int FNUM_PAD = WORD_W - FNUM_W;
  localparam int LST_PAD  = WORD_W - LST_W;

  logic [WORD_W-1:0] ivl_word;
  logic [LST_W-1:0]  lst;
  logic              frame_edge;
  logic [FNUM_W-1:0] fnum;
  logic [IVL_W-1:0]  rem;
  logic              rem_tgl;
  logic              oper_now;

  uft_interval_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ivl_word (ivl_word),
    .lst      (lst)
  );

  uft_frame_core #(.FNUM_W(FNUM_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .hc_state   (hc_state),
    .ivl        (ivl_word[IVL_W-1:0]),
    .ivl_tgl    (ivl_word[WORD_W-1]),
    .frame_edge (frame_edge),
    .sof_o      (sof_o),
    .fno_o      (fno_o),
    .fnum       (fnum),
    .rem        (rem),
    .rem_tgl    (rem_tgl)
  );

  uft_done_delay #(.DLY_W(DLY_W)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_edge (frame_edge),
    .retire_vld (retire_vld),
    .retire_dly (retire_dly),
    .wb_pend_i  (wb_pend_i),
    .irq_any_i  (irq_any_i),
    .wb_req_o   (wb_req_o),
    .wb_flag_o  (wb_flag_o)
  );

  assign oper_now = (hc_state == ST_OPER);

  always_comb begin
    case (rd_addr)
      RA_IVL:  rd_data = ivl_word;
      RA_REM:  rd_data = oper_now ? {rem_tgl, {REM_PAD{1'b0}}, rem}
                                  : {rem_tgl, {(WORD_W-1){1'b0}}};
      RA_FNUM: rd_data = {{FNUM_PAD{1'b0}}, fnum};
      default: rd_data = {{LST_PAD{1'b0}}, lst};
    endcase
  end

  // R11: every writeback request lands on a start-of-frame
  a_r11_wb_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o |-> sof_o);
endmodule

// File: tb/usb_frame_timer_test.sv
module usb_frame_timer_test;
  localparam int FNUM_W = 6;
  localparam int DLY_W  = 3;
  localparam int FMOD   = 1 << FNUM_W;

  logic             clk, rst_n, bit_tick, wr_en, retire_vld, wb_pend_i, irq_any_i;
  logic [1:0]       hc_state, wr_addr, rd_addr;
  logic [31:0]      wr_data, rd_data;
  logic [DLY_W-1:0] retire_dly;
  logic             sof_o, fno_o, wb_req_o, wb_flag_o;

  usb_frame_timer #(.FNUM_W(FNUM_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hc_state(hc_state),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .retire_vld(retire_vld), .retire_dly(retire_dly),
    .wb_pend_i(wb_pend_i), .irq_any_i(irq_any_i),
    .sof_o(sof_o), .fno_o(fno_o), .wb_req_o(wb_req_o), .wb_flag_o(wb_flag_o)
  );

  typedef struct {
    bit          boundary;
    int unsigned fnum;
    bit          ovf;
    bit          wb;
    bit          flag;
  } sof_item_t;

  sof_item_t   exp_q[$];
  int unsigned vectors = 0, miscompares = 0;
  int unsigned cyc = 0, last_sof = 0, wb_seen = 0, ovf_seen = 0;
  int unsigned m_fnum = 0, m_dc = 7;
  bit          done = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops one expected item per start-of-frame pulse
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wb_req_o) wb_seen++;
      if (fno_o) ovf_seen++;
      if (sof_o) begin
        if (exp_q.size() == 0) begin
          chk("R8 unexpected start-of-frame", 32'd1, 32'd0);
        end else begin
          sof_item_t it;
          it = exp_q.pop_front();
          if (rd_addr == 2'd2) chk("R5 frame number", rd_data, 32'(it.fnum));
          if (it.boundary) chk("R5 frame length", 32'(cyc - last_sof), 32'd4);
          else chk("R4 no increment on entry", rd_data, 32'(it.fnum));
          chk("R9 overflow pulse", 32'(fno_o), 32'(it.ovf));
          chk("R11 writeback request", 32'(wb_req_o), 32'(it.wb));
          if (it.wb) chk("R11 writeback flag", 32'(wb_flag_o), 32'(it.flag));
        end
        last_sof = cyc;
      end else if (wb_req_o) begin
        chk("R11 writeback without sof", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [31:0] d);
    logic [1:0] keep;
    keep = rd_addr;
    rd_addr = a;
    #1 d = rd_data;
    rd_addr = keep;
  endtask

  task automatic enter_op();
    sof_item_t it;
    it = '{boundary: 1'b0, fnum: m_fnum, ovf: 1'b0, wb: 1'b0, flag: 1'b0};
    exp_q.push_back(it);
    @(negedge clk);
    hc_state = 2'b10;
    wait (exp_q.size() == 0);
  endtask

  task automatic run_frames(input int n, input bit do_ret, input int dly);
    for (int i = 0; i < n; i++) begin
      sof_item_t it;
      int unsigned nf;
      bit wb;
      @(negedge clk);
      if (do_ret && i == 0) begin
        retire_vld = 1'b1; retire_dly = DLY_W'(dly);
        if (dly < m_dc) m_dc = dly;
        @(negedge clk);
        retire_vld = 1'b0;
      end
      wb = (m_dc == 0) && !wb_pend_i;
      if (wb) m_dc = 7;
      else if (m_dc != 7 && m_dc != 0) m_dc--;
      nf = (m_fnum + 1) % FMOD;
      it = '{boundary: 1'b1, fnum: nf,
             ovf: (((nf >> (FNUM_W-1)) & 1) != ((m_fnum >> (FNUM_W-1)) & 1)),
             wb: wb, flag: wb ? irq_any_i : 1'b0};
      m_fnum = nf;
      exp_q.push_back(it);
      wait (exp_q.size() == 0);
    end
  endtask

  initial begin
    logic [31:0] rv;
    int unsigned base;
    rst_n = 1'b0; bit_tick = 1'b1; hc_state = 2'b00; wr_en = 1'b0;
    wr_addr = 2'd0; wr_data = '0; rd_addr = 2'd2; retire_vld = 1'b0;
    retire_dly = '0; wb_pend_i = 1'b0; irq_any_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    read_at(2'd0, rv); chk("R1 interval reset", rv, 32'h2778_2EDF);
    read_at(2'd1, rv); chk("R1 remaining reset", rv, 32'h0);
    read_at(2'd2, rv); chk("R1 frame number reset", rv, 32'h0);
    read_at(2'd3, rv); chk("R1 threshold reset", rv, 32'h628);
    chk("R1 outputs idle", {28'h0, sof_o, fno_o, wb_req_o, wb_flag_o}, 32'h0);

    reg_wr(2'd0, 32'h2778_C003);
    read_at(2'd0, rv); chk("R2 interval write, bits 15:14 zero", rv, 32'h2778_0003);
    reg_wr(2'd3, 32'hFFFF_F123);
    read_at(2'd3, rv); chk("R3 threshold keeps 11:0", rv, 32'h123);
    reg_wr(2'd2, 32'h0000_0055);
    reg_wr(2'd1, 32'h0000_1234);
    read_at(2'd2, rv); chk("R3 frame number not writable", rv, 32'h0);
    read_at(2'd1, rv); chk("R3 remaining not writable", rv, 32'h0);

    enter_op();
    read_at(2'd1, rv); chk("R4 remaining loaded on entry", rv, 32'h3);

    base = wb_seen;
    run_frames(3, 1'b0, 0);
    chk("R10 counter at 7 after reset gives no writeback", wb_seen - base, 0);

    // toggle programmed mid-frame; remaining toggle follows at next boundary
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hA778_0003;
    @(negedge clk);
    wr_en = 1'b0;
    read_at(2'd1, rv); chk("R7 toggle not yet copied", {31'h0, rv[31]}, 32'h0);
    run_frames(1, 1'b0, 0);
    read_at(2'd1, rv); chk("R7 toggle copied at boundary", rv, 32'h8000_0003);
    read_at(2'd1, rv); chk("R6 remaining read while operational", {rv[31], 17'h0, rv[13:0]}, rv);

    // suspend stops frames
    @(negedge clk);
    hc_state = 2'b11;
    repeat (20) @(negedge clk);
    read_at(2'd2, rv); chk("R8 frame number held in suspend", rv, 32'(m_fnum));
    read_at(2'd1, rv); chk("R6 remaining shows toggle only", rv, 32'h8000_0000);
    enter_op();

    irq_any_i = 1'b1;
    base = wb_seen;
    run_frames(3, 1'b1, 3);
    chk("R13 delay 3 steps down without writeback", wb_seen - base, 0);
    run_frames(1, 1'b0, 0);
    chk("R11 writeback on fourth boundary", wb_seen - base, 1);

    base = wb_seen;
    run_frames(1, 1'b1, 5);
    run_frames(1, 1'b1, 6);
    run_frames(1, 1'b1, 2);
    chk("R10 larger delay ignored, smaller taken", wb_seen - base, 0);
    run_frames(2, 1'b0, 0);
    chk("R10 writeback after minimum delay", wb_seen - base, 1);

    wb_pend_i = 1'b1;
    base = wb_seen;
    run_frames(3, 1'b1, 0);
    chk("R12 pending writeback blocks request", wb_seen - base, 0);
    wb_pend_i = 1'b0; irq_any_i = 1'b0;
    run_frames(1, 1'b0, 0);
    chk("R12 request once pending clears", wb_seen - base, 1);

    base = ovf_seen;
    run_frames(FMOD, 1'b0, 0);
    chk("R9 two top-bit changes over a full wrap", ovf_seen - base, 2);
    read_at(2'd2, rv); chk("R5 frame number after wrap", rv, 32'(m_fnum));

    repeat (2) @(negedge clk);
    chk("R8 no leftover expected frames", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule